// File: doc/BRIEF.md
# One-Shot Match-Compare Operating-System Timer

This block is a memory-mapped timer for an operating-system tick. It holds a 32-bit counter view, one match value, a sticky expiry flag and an interrupt enable word. Software arms a single countdown by writing a new match value. The countdown then consumes one step on each cycle where the tick-enable input is high. That input is a strobe derived from a 50 MHz time base.

When the countdown runs out, the counter takes the match value and freezes. If the enable word is nonzero, the flag is set and the level interrupt goes high. Software acknowledges by writing zero to the flag. Nothing else moves until the match value is written again. The register port is a plain word-wide interface: address, write strobe, write data, and a read-data output that always reflects the addressed register.

Top module: `os_match_timer`

## Requirements
- R1: After reset, the counter, match, flag and enable registers are all zero, reads of every offset return zero, and the interrupt is low.
- R2: The word offsets are fixed: 0x10 reads the counter, 0x14 reads and writes the flag, and 0x1C reads and writes the enable word. 0x00 is the match register, which is write-only and reads zero. Every other offset reads zero, and any write to it is ignored. A write to 0x10 changes nothing.
- R3: A match write arms a countdown. Its length is (match − counter) when the match is above the stored counter, and (match + 0xFFFFFFFF − counter) mod 2^32 otherwise. Directly after arming, the counter reads match minus that length.
- R4: While armed, each cycle with the tick input high shortens the countdown by one, and the counter read rises by one. Cycles with the tick input low change nothing.
- R5: On the tick that ends the countdown, the counter becomes the match value. Further ticks leave it unchanged.
- R6: On expiry with the enable word nonzero, the flag reads 1. With the enable word zero, expiry changes only the counter.
- R7: Writing zero to the flag clears it. Writing a nonzero value to the flag has no effect.
- R8: If a flag-clear write and an expiry fall in the same cycle, the flag ends up set.
- R9: A match write re-arms the timer at any time, including while a countdown runs. A match write in the same cycle as the final tick re-arms the timer, and no expiry takes place.
- R10: The interrupt output is high exactly when the flag reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Time-base strobe; one countdown step per high cycle |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Contents of the addressed register (combinational) |
| irq | output | 1 | Level interrupt, mirrors the flag |

## Verification
A corrupted remaining-count or armed state appears at the counter offset in the very cycle after it occurs, because the read value is derived from the remaining count while armed. It also shows up later as an expiry that arrives early, arrives late, or never comes. A wrong flag or enable state reaches the interrupt pin and the flag offset on the same clock. The bench therefore compares the read data at the current address and the interrupt against a behavioural model on every clock. It sweeps the address so that each register is observed between events.

// File: rtl/ost_pkg.sv
package ost_pkg;

    localparam logic [7:0] OFS_MATCH  = 8'h00;
    localparam logic [7:0] OFS_COUNT  = 8'h10;
    localparam logic [7:0] OFS_STATUS = 8'h14;
    localparam logic [7:0] OFS_ENABLE = 8'h1C;

    typedef struct packed {
        logic wr_match;
        logic wr_status;
        logic wr_enable;
        logic rd_count;
        logic rd_status;
        logic rd_enable;
    } ost_sel_t;

endpackage

// File: rtl/ost_decode.sv
module ost_decode
    import ost_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    output ost_sel_t          sel_o
);

    localparam logic [ADDR_W-1:0] A_MATCH  = ADDR_W'(OFS_MATCH);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);

    always_comb begin
        sel_o           = '0;
        sel_o.wr_match  = we_i && (addr_i == A_MATCH);
        sel_o.wr_status = we_i && (addr_i == A_STATUS);
        sel_o.wr_enable = we_i && (addr_i == A_ENABLE);
        sel_o.rd_count  = (addr_i == A_COUNT);
        sel_o.rd_status = (addr_i == A_STATUS);
        sel_o.rd_enable = (addr_i == A_ENABLE);
    end

endmodule

// File: rtl/ost_countdown.sv
module ost_countdown #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              tick_i,
    output logic              expire_o,
    output logic [DATA_W-1:0] count_view_o
);

    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

    typedef struct packed {
        logic              run;
        logic [DATA_W-1:0] match;
        logic [DATA_W-1:0] left;
        logic [DATA_W-1:0] cnt;
    } cd_t;

    cd_t               cd_d, cd_q;
    logic [DATA_W-1:0] span;
    logic              step;

    always_comb begin
        cd_d     = cd_q;
        span     = (wdata_i > cd_q.cnt) ? (wdata_i - cd_q.cnt)
                                        : (wdata_i + (ALL_ONES - cd_q.cnt));
        step     = cd_q.run && tick_i && !arm_i;
        expire_o = step && (cd_q.left <= ONE);
        if (arm_i) begin
            cd_d.match = wdata_i;
            cd_d.left  = span;
            cd_d.run   = 1'b1;
        end else if (expire_o) begin
            cd_d.cnt  = cd_q.match;
            cd_d.left = '0;
            cd_d.run  = 1'b0;
        end else if (step) begin
            cd_d.left = cd_q.left - ONE;
        end
        count_view_o = cd_q.run ? (cd_q.match - cd_q.left) : cd_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cd_q <= '0;
        else        cd_q <= cd_d;
    end

    assert_arm_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> cd_q.run);

    assert_expire_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (!cd_q.run && count_view_o == $past(cd_q.match)));

    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cd_q.run && !arm_i) |=> $stable(count_view_o));

    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_q.run && tick_i && !arm_i && !expire_o) |=>
            count_view_o == $past(count_view_o) + ONE);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_q.run && !tick_i && !arm_i) |=> $stable(count_view_o));

endmodule

// File: rtl/ost_irqflag.sv
module ost_irqflag #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sts_wr_i,
    input  logic              ien_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              expire_i,
    output logic              flag_o,
    output logic [DATA_W-1:0] ien_o
);

    typedef struct packed {
        logic              flag;
        logic [DATA_W-1:0] ien;
    } fl_t;

    fl_t  fl_d, fl_q;
    logic raise, clear;

    always_comb begin
        fl_d  = fl_q;
        raise = expire_i && (fl_q.ien != '0);
        clear = sts_wr_i && (wdata_i == '0) && fl_q.flag;
        if (raise)      fl_d.flag = 1'b1;
        else if (clear) fl_d.flag = 1'b0;
        if (ien_wr_i)   fl_d.ien  = wdata_i;
        flag_o = fl_q.flag;
        ien_o  = fl_q.ien;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assert_gated_by_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.flag) |-> ($past(fl_q.ien) != '0 && $past(expire_i)));

    assert_zero_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr_i && wdata_i == '0 && !expire_i) |=> !fl_q.flag);

    assert_nonzero_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr_i && wdata_i != '0 && !expire_i) |=> $stable(fl_q.flag));

    assert_expiry_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && fl_q.ien != '0) |=> fl_q.flag);

endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
    import ost_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    ost_sel_t          sel;
    logic              expire;
    logic              flag;
    logic [DATA_W-1:0] count_view;
    logic [DATA_W-1:0] ien;

    ost_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (bus_addr),
        .we_i   (bus_we),
        .sel_o  (sel)
    );

    ost_countdown #(.DATA_W(DATA_W)) u_countdown (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_i        (sel.wr_match),
        .wdata_i      (bus_wdata),
        .tick_i       (tick_en),
        .expire_o     (expire),
        .count_view_o (count_view)
    );

    ost_irqflag #(.DATA_W(DATA_W)) u_irqflag (
        .clk      (clk),
        .rst_n    (rst_n),
        .sts_wr_i (sel.wr_status),
        .ien_wr_i (sel.wr_enable),
        .wdata_i  (bus_wdata),
        .expire_i (expire),
        .flag_o   (flag),
        .ien_o    (ien)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel.rd_count)  bus_rdata = count_view;
        if (sel.rd_status) bus_rdata = DATA_W'(flag);
        if (sel.rd_enable) bus_rdata = ien;
        irq = flag;
    end

    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel.rd_count || sel.rd_status || sel.rd_enable) |-> bus_rdata == '0);

    assert_irq_follows_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sel.rd_status |-> (bus_rdata == DATA_W'(irq)));

endmodule

// File: tb/tb_os_match_timer.sv
`timescale 1ns/1ps
module tb_os_match_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int    n_tests = 0;
    int    n_fail = 0;
    bit    mon_en = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    os_match_timer #(.ADDR_W(5), .DATA_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference
    bit [31:0] m_cnt, m_match, m_left, m_ien;
    bit        m_run, m_sts;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_match = 0; m_left = 0; m_ien = 0; m_run = 0; m_sts = 0;
        end else begin
            bit arm, ex, clr;
            arm = bus_we && bus_addr == 5'h00;
            ex  = m_run && tick_en && !arm && m_left <= 1;
            clr = bus_we && bus_addr == 5'h14 && bus_wdata == 0;
            if (ex && m_ien != 0) m_sts = 1;
            else if (clr)         m_sts = 0;
            if (bus_we && bus_addr == 5'h1C) m_ien = bus_wdata;
            if (arm) begin
                m_match = bus_wdata;
                m_left  = (bus_wdata > m_cnt) ? bus_wdata - m_cnt
                                              : bus_wdata + (32'hFFFF_FFFF - m_cnt);
                m_run   = 1;
            end else if (ex) begin
                m_cnt = m_match; m_run = 0;
            end else if (m_run && tick_en) begin
                m_left = m_left - 1;
            end
        end
    end

    function automatic bit [31:0] model_read(input bit [4:0] a);
        case (a)
            5'h10:   return m_run ? m_match - m_left : m_cnt;
            5'h14:   return {31'b0, m_sts};
            5'h1C:   return m_ien;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input bit [31:0] act, input bit [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // every-clock comparison, late in the low phase
    always begin
        @(negedge clk);
        #3;
        if (rst_n && mon_en) begin
            chk({cur_req, " rdata"}, bus_rdata, model_read(bus_addr));
            chk("R10 irq", {31'b0, irq}, {31'b0, m_sts});
        end
    end

    task automatic cyc(input bit [4:0] a, input bit we, input bit [31:0] d, input bit tk);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = d; tick_en = tk;
    endtask

    task automatic wr(input bit [4:0] a, input bit [31:0] d);
        cyc(a, 1'b1, d, 1'b0);
        cyc(5'h10, 1'b0, 0, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(5'h10, 1'b0, 0, 1'b1);
            cyc(5'h10, 1'b0, 0, 1'b0);
        end
    endtask

    task automatic rd(input bit [4:0] a, input bit [31:0] exp, input string req);
        cyc(a, 1'b0, 0, 1'b0);
        #3;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(5'h10, 0, "R1 counter");
        rd(5'h14, 0, "R1 status");
        rd(5'h1C, 0, "R1 enable");
        rd(5'h00, 0, "R1 match");
        chk("R1 irq", {31'b0, irq}, 0);
        mon_en = 1'b1;
        // R2 map
        cur_req = "R2";
        wr(5'h1C, 32'h0000_00A5);
        rd(5'h1C, 32'h0000_00A5, "R2 enable readback");
        wr(5'h04, 32'hDEAD_BEEF);
        rd(5'h04, 0, "R2 unmapped read");
        wr(5'h10, 32'h1234_5678);
        rd(5'h10, 0, "R2 counter write ignored");
        wr(5'h1C, 0);
        rd(5'h1C, 0, "R2 enable cleared");
        // R3 R4 R5 with interrupts off
        cur_req = "R4";
        wr(5'h00, 5);
        rd(5'h00, 0, "R2 match write-only");
        rd(5'h10, 0, "R3 armed view");
        ticks(2);
        rd(5'h10, 2, "R4 two ticks");
        cyc(5'h10, 1'b0, 0, 1'b0);
        cyc(5'h10, 1'b0, 0, 1'b0);
        rd(5'h10, 2, "R4 no tick no change");
        ticks(3);
        rd(5'h10, 5, "R5 at match");
        rd(5'h14, 0, "R6 no flag when disabled");
        ticks(3);
        rd(5'h10, 5, "R5 frozen");
        // R3 wrap
        cur_req = "R3";
        wr(5'h1C, 1);
        wr(5'h00, 3);
        rd(5'h10, 6, "R3 wrapped distance");
        ticks(2);
        rd(5'h10, 8, "R4 wrap run");
        // R9 re-arm while running
        cur_req = "R9";
        wr(5'h00, 9);
        rd(5'h10, 5, "R9 re-arm view");
        ticks(4);
        rd(5'h10, 9, "R5 expiry value");
        rd(5'h14, 1, "R6 flag set");
        chk("R10 irq high", {31'b0, irq}, 1);
        // R7
        cur_req = "R7";
        wr(5'h14, 7);
        rd(5'h14, 1, "R7 nonzero write ignored");
        wr(5'h14, 0);
        rd(5'h14, 0, "R7 clear");
        chk("R10 irq low", {31'b0, irq}, 0);
        // R8
        cur_req = "R8";
        wr(5'h00, 11);
        ticks(1);
        cyc(5'h14, 1'b1, 0, 1'b1);
        rd(5'h14, 1, "R8 expiry wins");
        rd(5'h10, 11, "R8 counter");
        wr(5'h14, 0);
        // R9 arm on final tick
        cur_req = "R9";
        wr(5'h00, 15);
        ticks(3);
        rd(5'h10, 14, "R9 before last tick");
        cyc(5'h00, 1'b1, 20, 1'b1);
        rd(5'h10, 11, "R9 arm beats expiry");
        rd(5'h14, 0, "R9 no expiry flag");
        ticks(9);
        rd(5'h10, 20, "R9 rearmed expiry");
        rd(5'h14, 1, "R9 flag after rearm");
        mon_en = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule